// File: doc/BRIEF.md
# Local IO interrupt router

This block collects 32 interrupt sources and hands them to 4 processor cores, each core having 4 parent interrupt lines. Every source is first conditioned by its own trigger type: active-high level, active-low level, rising edge or falling edge. It is then gated by an enable bit. Finally it is steered by an 8-bit route byte. The low nibble of the route byte picks the cores that receive the source. The high nibble picks the parent lines on those cores.

Software drives the block through a simple register bus of 32-bit words with byte enables. Reads are combinational on the address. The bus holds these registers:

- the route bytes;
- set-enable and clear-enable write-one ports, plus a readback of the enable mask;
- polarity and edge-mode words;
- one pending word per core.

An edge-mode source keeps a sticky pending bit. A write of ones to any core's pending word clears those bits. The 16 outputs are ordered core-major. Output index core*4+line is raised while any enabled, pending source is routed to that core and that line.

Top module: `lio_irq_router`

## Requirements
- R1: After reset, the enable mask, polarity, edge mode and all route bytes read as 0, every pending word reads 0, and all outputs are low.
- R2: Route byte of source i sits at byte address i (0x00-0x1F), so byte k of the word at 4*w holds source 4*w+k. Bits 3:0 are a core bitmap (bit c means core c) and bits 7:4 are a line bitmap (bit 4+p means line p). A write updates only the bytes whose byte enable is set.
- R3: Writing 1s to 0x28 sets those enable bits and writing 1s to 0x2C clears them. Zero bits leave enables unchanged. 0x24 reads the enable mask, with bit i belonging to source i.
- R4: 0x30 (polarity) and 0x34 (edge mode) are read/write words with bit i for source i. Edge 0 with polarity 0 is level-high, edge 0 with polarity 1 is level-low, edge 1 with polarity 0 is rising, and edge 1 with polarity 1 is falling.
- R5: A level-mode source is pending while its registered, polarity-corrected sample is 1. It drops as soon as that sample is 0.
- R6: An edge-mode source becomes pending on a 0-to-1 change of its polarity-corrected sample. It stays pending after the input returns. A change in the opposite direction sets nothing.
- R7: Writing 1s to the pending word of any core (0x40, 0x48, 0x50, 0x58) clears those sticky edge bits. Zero bits clear nothing.
- R8: The pending word of core c at 0x40+8*c shows bit i set when source i is enabled, pending and its core bitmap has bit c.
- R9: Output bit c*4+p is high when any enabled pending source has core bit c and line bit p. A source routed to several cores drives all of them.
- R10: A disabled source shows in no pending word and drives no output, but its sticky edge bit is kept and shows again once the source is re-enabled. Writing 0xFFFFFFFF to 0x2C masks every source.
- R11: Returning a source to level mode discards its sticky edge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt sources, synchronous to clk |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 16 | Per core and line request, index core*4+line |

## Verification
Several checks hold on every cycle:

- outputs stay low while the enable mask is empty;
- a full-mask clear write empties the enable mask;
- a set write leaves the written bits enabled;
- sticky edge bits never survive a cycle in which their source was in level mode;
- the state just after reset is clean.

The bench scenarios cover the rest. These are the route decoding and byte-lane writes, each of the four trigger types, and stickiness after the input returns. They also cover clearing through another core's pending word and multi-core delivery. Finally they show that a latched edge survives disabling and is discarded when the source returns to level mode.

// File: rtl/lio_irq_router.sv
module lio_irq_router #(
  parameter int NSRC  = 32,
  parameter int NCORE = 4,
  parameter int NLINE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NCORE*NLINE-1:0] irq_o
);
  localparam int NRW = NSRC / 4;

  logic [NSRC-1:0] en_q, pol_q, edge_q, smp_q, prev_q, stick_q;
  logic [7:0]      route_q [NSRC];
  logic [NSRC-1:0] core_map [NCORE];
  logic [NSRC-1:0] line_map [NLINE];
  logic [NSRC-1:0] core_pend [NCORE];

  wire        wr    = bus_en & bus_we;
  wire [5:0]  widx  = bus_addr[7:2];
  wire [31:0] bmask = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  wire [NSRC-1:0] wbits = NSRC'(bus_wdata & bmask);

  wire [NSRC-1:0] cond  = smp_q ^ pol_q;
  wire [NSRC-1:0] rise  = cond & ~prev_q & edge_q;
  wire            clr_hit = wr && widx[5:3] == 3'd2 && !widx[0];
  wire [NSRC-1:0] live  = ((edge_q & stick_q) | (~edge_q & cond)) & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      smp_q   <= '0;
      prev_q  <= '0;
      stick_q <= '0;
      for (int i = 0; i < NSRC; i++) route_q[i] <= '0;
    end else begin
      smp_q   <= src_i;
      prev_q  <= cond;
      stick_q <= ((stick_q & ~(clr_hit ? wbits : '0)) | rise) & edge_q;
      if (wr && widx == 6'd10) en_q <= en_q | wbits;
      if (wr && widx == 6'd11) en_q <= en_q & ~wbits;
      if (wr && widx == 6'd12) pol_q  <= (pol_q & ~NSRC'(bmask)) | wbits;
      if (wr && widx == 6'd13) edge_q <= (edge_q & ~NSRC'(bmask)) | wbits;
      for (int i = 0; i < NSRC; i++)
        if (wr && widx == 6'(i / 4) && bus_be[i % 4])
          route_q[i] <= bus_wdata[8*(i%4) +: 8];
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar i = 0; i < NSRC; i++) begin : g_cm
      assign core_map[c][i] = route_q[i][c];
    end
    assign core_pend[c] = live & core_map[c];
  end

  for (genvar p = 0; p < NLINE; p++) begin : g_line
    for (genvar i = 0; i < NSRC; i++) begin : g_lm
      assign line_map[p][i] = route_q[i][4+p];
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_oc
    for (genvar p = 0; p < NLINE; p++) begin : g_op
      assign irq_o[c*NLINE+p] = |(core_pend[c] & line_map[p]);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (widx < 6'(NRW)) begin
      for (int k = 0; k < 4; k++) bus_rdata[8*k +: 8] = route_q[4*widx[2:0] + k];
    end else begin
      case (widx)
        6'd9:  bus_rdata = 32'(en_q);
        6'd12: bus_rdata = 32'(pol_q);
        6'd13: bus_rdata = 32'(edge_q);
        6'd16, 6'd18, 6'd20, 6'd22: bus_rdata = 32'(core_pend[widx[2:1]]);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module lio_irq_router_chk #(
  parameter int NSRC = 32,
  parameter int NOUT = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_en,
  input logic            bus_we,
  input logic [7:0]      bus_addr,
  input logic [3:0]      bus_be,
  input logic [31:0]     bus_wdata,
  input logic [NOUT-1:0] irq_o,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] edge_q,
  input logic [NSRC-1:0] stick_q
);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && irq_o == '0));

  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[7:2] == 6'd10 && bus_be == 4'hF)
    |=> ((en_q & NSRC'($past(bus_wdata))) == NSRC'($past(bus_wdata))));

  assert_sticky_edge_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stick_q & ~$past(edge_q)) == '0);

  assert_quiet_when_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_q == '0 |-> irq_o == '0);

  assert_bulk_disable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr[7:2] == 6'd11 && bus_be == 4'hF && bus_wdata == 32'hFFFF_FFFF)
    |=> en_q == '0);
endmodule

bind lio_irq_router lio_irq_router_chk #(.NSRC(NSRC), .NOUT(NCORE*NLINE)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .irq_o(irq_o), .en_q(en_q),
  .edge_q(edge_q), .stick_q(stick_q)
);

// File: tb/lio_irq_router_tb.sv
module lio_irq_router_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src_i = '0;
  logic        bus_en = 0, bus_we = 0;
  logic [7:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_o;

  always #4 clk = ~clk;

  lio_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_err = 0;
  bit    mon_req = 0, done = 0;

  always @(negedge clk) begin
    if (mon_req && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = q.pop_front();
      act = it.is_irq ? {16'h0, irq_o} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #1;
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_en = 0; bus_we = 0; bus_be = '0;
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    bus_en = 1; bus_we = 0; bus_addr = a;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
    mon_req = 1;
    @(posedge clk); #1;
    mon_req = 0; bus_en = 0;
  endtask

  task automatic expect_irq(input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1; it.exp = {16'h0, e}; it.tag = tag;
    q.push_back(it);
    mon_req = 1;
    @(posedge clk); #1;
    mon_req = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    expect_rd(8'h24, 32'h0, "R1 enable");
    expect_rd(8'h30, 32'h0, "R1 polarity");
    expect_rd(8'h34, 32'h0, "R1 edge");
    expect_rd(8'h00, 32'h0, "R1 route");
    expect_rd(8'h40, 32'h0, "R1 pending");
    expect_irq(16'h0, "R1 outputs");

    // R2 routes: src0 0x11, src1 0x22, src2 0x34, src3 0x83; src5 0x55 by byte lane
    wr(8'h00, 32'h8334_2211, 4'hF);
    expect_rd(8'h00, 32'h8334_2211, "R2 word write");
    wr(8'h04, 32'hAAAA_55AA, 4'b0010);
    expect_rd(8'h04, 32'h0000_5500, "R2 byte lane");

    // R3 enables
    wr(8'h28, 32'h0000_002F, 4'hF);
    expect_rd(8'h24, 32'h0000_002F, "R3 set");
    wr(8'h2C, 32'h0000_0004, 4'hF);
    expect_rd(8'h24, 32'h0000_002B, "R3 clear");
    wr(8'h28, 32'h0000_0004, 4'hF);
    wr(8'h28, 32'h0, 4'hF);
    expect_rd(8'h24, 32'h0000_002F, "R3 zero bits no effect");

    // R5/R8/R9 level high
    src_i = 32'h1; tick(2);
    expect_rd(8'h40, 32'h1, "R8 core0 pending");
    expect_rd(8'h48, 32'h0, "R8 core1 not routed");
    expect_irq(16'h0001, "R9 core0 line0");
    src_i = 32'h0; tick(2);
    expect_rd(8'h40, 32'h0, "R5 level drops");
    src_i = 32'h8; tick(2);
    expect_irq(16'h0088, "R9 multi-core src3");
    expect_rd(8'h48, 32'h8, "R8 core1 src3");
    src_i = 32'h20; tick(2);
    expect_irq(16'h0505, "R9 src5 cores0,2 lines0,2");
    src_i = 32'h0; tick(2);

    // R4 level low on src1
    wr(8'h30, 32'h2, 4'hF);
    expect_rd(8'h30, 32'h2, "R4 polarity readback");
    expect_rd(8'h48, 32'h2, "R4 level-low active at 0");
    expect_irq(16'h0020, "R4 core1 line1");
    src_i = 32'h2; tick(2);
    expect_irq(16'h0000, "R4 level-low idle at 1");

    // R6 rising edge on src0
    wr(8'h34, 32'h1, 4'hF);
    expect_rd(8'h34, 32'h1, "R4 edge readback");
    src_i = 32'h3; tick(3);
    expect_rd(8'h40, 32'h1, "R6 rising latched");
    src_i = 32'h2; tick(3);
    expect_rd(8'h40, 32'h1, "R6 sticky after input low");
    wr(8'h48, 32'h1, 4'hF);
    expect_rd(8'h40, 32'h0, "R7 clear via other core");
    src_i = 32'h3; tick(3); src_i = 32'h2; tick(2);
    wr(8'h40, 32'h0, 4'hF);
    expect_rd(8'h40, 32'h1, "R7 zero bits keep");
    wr(8'h40, 32'h1, 4'hF);
    expect_rd(8'h40, 32'h0, "R7 clear own core");

    // R6 falling edge on src0
    wr(8'h30, 32'h3, 4'hF);
    tick(3);
    wr(8'h40, 32'h1, 4'hF);
    expect_rd(8'h40, 32'h0, "R7 clear after polarity change");
    src_i = 32'h3; tick(3);
    expect_rd(8'h40, 32'h0, "R6 falling ignores rise");
    src_i = 32'h2; tick(3);
    expect_rd(8'h40, 32'h1, "R6 falling latched");
    wr(8'h40, 32'h1, 4'hF);

    // R10 disabled but latched
    wr(8'h2C, 32'h1, 4'hF);
    src_i = 32'h3; tick(3); src_i = 32'h2; tick(3);
    expect_rd(8'h40, 32'h0, "R10 disabled hidden");
    expect_irq(16'h0, "R10 disabled no output");
    wr(8'h28, 32'h1, 4'hF);
    expect_rd(8'h40, 32'h1, "R10 latch kept");
    wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
    expect_rd(8'h24, 32'h0, "R10 bulk disable");
    src_i = 32'h8; tick(2);
    expect_irq(16'h0, "R10 all masked");

    // R11 edge -> level discards sticky
    wr(8'h28, 32'h1, 4'hF);
    src_i = 32'h3; tick(2);
    wr(8'h34, 32'h0, 4'hF);
    tick(2);
    expect_rd(8'h40, 32'h0, "R11 level-low src0 idle");
    wr(8'h34, 32'h1, 4'hF);
    tick(2);
    expect_rd(8'h40, 32'h0, "R11 sticky discarded");

    tick(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule